// File: doc/BRIEF.md
# Programmable Memory Attribute Checker

This block decides, for every physical memory access, whether the access is allowed and what kind of memory it targets. It holds a table of region entries. Each entry has an address register and an 8-bit attribute byte. Regions are matched the way a RISC-V PMP matches them. Beyond the usual read, write and execute permissions, each attribute byte also marks whether its region is cacheable and whether it accepts atomic operations. A lookup that lands in a non-cacheable region is reported as MMIO.

Software programs the table through machine-level custom CSRs. A CSR write changes the table only when it is issued in machine mode. The check itself is applied in every privilege mode, machine mode included, and the lock bit exempts no access from it. After reset the table holds a fixed map: a low non-cacheable window and a cacheable main-memory window above it. This lets the system boot before software reprograms the table.

The pipeline presents a physical address and an access kind on the lookup port. One clock later the block returns an access-fault flag, an MMIO flag and an atomic-capable flag.

Top module: `pma_attr_unit`

## Requirements
- R1: The unit holds 16 entries behind 20 CSRs. Config CSRs 0x7C0..0x7C3 hold four attribute bytes each, and byte b (bits 8b+7..8b) of CSR c belongs to entry 4c+b. Address CSRs 0x7D0..0x7DF hold bits 33..2 of each entry's physical address. `csr_rdata_o` returns the addressed CSR combinationally in the same cycle.
- R2: A CSR write changes state only when `priv_i` is 3 (machine mode). Writes made with any other `priv_i` value are ignored.
- R3: The attribute byte is laid out as follows: bit 7 lock, bit 6 atomic-capable, bit 5 cacheable, bits 4..3 match mode, bit 2 execute, bit 1 write, bit 0 read. The match mode values are 0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power of two.
- R4: Matching works on the word address (address bits 33..2):
  - A top-of-range entry matches when the word address is at least the previous entry's address register and below its own. Entry 0 uses zero as its lower bound.
  - A 4-byte entry matches its exact word.
  - A power-of-two entry with k trailing ones in its address register covers 2^(k+3) bytes.
  - When several entries match, the lowest-numbered one wins.
- R5: Access kinds are encoded on `req_type_i` as fetch 0, load 1, store 2, atomic 3 and page-table walk 4. A fetch needs execute, a load needs read and a store needs write. An atomic access needs read, write and the atomic-capable bit. A missing permission raises `rsp_fault_o`. `rsp_atomic_o` returns the winning entry's atomic-capable bit.
- R6: An access that matches no entry reports fault 1, MMIO 1 and atomic 0.
- R7: `rsp_valid_o` is asserted exactly one cycle after `req_valid_i`. The response reflects the table contents in the cycle of the request, even if a CSR write lands at the same edge.
- R8: `rsp_mmio_o` is the inverse of the winning entry's cacheable bit. A page-table-walk access needs read permission and faults whenever it resolves to an MMIO region.
- R9: Once an entry is locked, writes to its attribute byte and its address register are ignored. Other bytes of the same config CSR stay writable. Locked entries are checked like any other entry, in every privilege mode.
- R10: After reset the table holds these values:
  - Entry 0: top-of-range at byte address 0x8000_0000, attribute byte 0x0F (read/write/execute, non-cacheable).
  - Entry 1: top-of-range at byte address 0x2_0000_0000, attribute byte 0x6F (read/write/execute, cacheable, atomic).
  - All other entries: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN (32) | CSR write data |
| priv_i | input | 2 | Privilege level of the CSR access (3 = machine) |
| csr_rdata_o | output | XLEN (32) | CSR read data for `csr_addr_i` |
| req_valid_i | input | 1 | Lookup request valid |
| req_addr_i | input | PADDR_W (34) | Physical address to check |
| req_type_i | input | 3 | Access kind |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_fault_o | output | 1 | Access fault |
| rsp_mmio_o | output | 1 | Target is non-cacheable (MMIO) |
| rsp_atomic_o | output | 1 | Target region accepts atomic operations |

## Verification
The bench uses the defaults: 16 entries, a 34-bit physical address and 32-bit CSRs. With these values the reset map covers only the low 8 GiB, so the bench can program new regions between 8 GiB and 16 GiB without disturbing the boot windows, and addresses outside every region are easy to reach. Using all four match modes in neighbouring entries makes it possible to test a top-of-range entry taking its lower bound from a 4-byte entry, and to test priority between overlapping entries. It also exercises locking one byte inside a config CSR while its neighbour stays writable.

// File: rtl/pma_pkg.sv
package pma_pkg;
  typedef enum logic [2:0] {
    ACC_FETCH  = 3'd0,
    ACC_LOAD   = 3'd1,
    ACC_STORE  = 3'd2,
    ACC_ATOMIC = 3'd3,
    ACC_PTW    = 3'd4
  } acc_e;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_e;

  typedef struct packed {
    logic   lock;
    logic   amo;
    logic   cache;
    match_e mode;
    logic   x;
    logic   w;
    logic   r;
  } cfg_t;

  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/pma_csr_file.sv
module pma_csr_file
  import pma_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned AW          = 32,
  parameter int unsigned CFG_BASE    = 'h7C0,
  parameter int unsigned ADDR_BASE   = 'h7D0,
  parameter int unsigned DEF_LO_TOP  = 32'h2000_0000,
  parameter int unsigned DEF_HI_TOP  = 32'h8000_0000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [11:0]                     addr_i,
  input  logic [XLEN-1:0]                 wdata_i,
  input  logic [1:0]                      priv_i,
  output logic [XLEN-1:0]                 rdata_o,
  output cfg_t [NUM_ENTRIES-1:0]          cfg_o,
  output logic [NUM_ENTRIES-1:0][AW-1:0]  addr_o
);
  localparam int unsigned BPC  = XLEN / 8;
  localparam int unsigned NCFG = NUM_ENTRIES / BPC;

  function automatic cfg_t def_cfg(input int unsigned idx);
    cfg_t c;
    c = '0;
    if (idx < 2) begin
      c.mode = MATCH_TOR;
      c.x = 1'b1; c.w = 1'b1; c.r = 1'b1;
      c.amo = (idx == 1);
      c.cache = (idx == 1);
    end
    return c;
  endfunction

  function automatic logic [AW-1:0] def_addr(input int unsigned idx);
    if (idx == 0) return AW'(DEF_LO_TOP);
    if (idx == 1) return AW'(DEF_HI_TOP);
    return '0;
  endfunction

  logic we_ok;
  assign we_ok = we_i && (priv_i == PRIV_M);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    localparam int unsigned CI = e / BPC;
    localparam int unsigned BI = e % BPC;
    cfg_t          cfg_q;
    logic [AW-1:0] addr_q;
    logic          cfg_sel, addr_sel;

    assign cfg_sel  = we_ok && (addr_i == 12'(CFG_BASE + CI));
    assign addr_sel = we_ok && (addr_i == 12'(ADDR_BASE + e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q  <= def_cfg(e);
        addr_q <= def_addr(e);
      end else if (!cfg_q.lock) begin
        if (cfg_sel)  cfg_q  <= cfg_t'(wdata_i[8*BI +: 8]);
        if (addr_sel) addr_q <= wdata_i[AW-1:0];
      end
    end

    assign cfg_o[e]  = cfg_q;
    assign addr_o[e] = addr_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCFG; c++) begin
      if (addr_i == 12'(CFG_BASE + c)) begin
        for (int b = 0; b < BPC; b++) rdata_o[8*b +: 8] = cfg_o[c*BPC + b];
      end
    end
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (addr_i == 12'(ADDR_BASE + e)) rdata_o = XLEN'(addr_o[e]);
    end
  end
endmodule

// File: rtl/pma_entry_match.sv
module pma_entry_match
  import pma_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  match_e        mode_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] word_i,
  output logic          hit_o
);
  logic [AW-1:0] care_n;

  // trailing ones plus the first zero are don't-care bits
  assign care_n = top_i ^ (top_i + 1'b1);

  always_comb begin
    unique case (mode_i)
      MATCH_TOR:   hit_o = (word_i >= base_i) && (word_i < top_i);
      MATCH_NA4:   hit_o = (word_i == top_i);
      MATCH_NAPOT: hit_o = ((word_i | care_n) == (top_i | care_n));
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pma_resolve.sv
module pma_resolve
  import pma_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] hit_i,
  input  cfg_t [NUM_ENTRIES-1:0] cfg_i,
  input  logic [2:0]             type_i,
  output logic                   any_hit_o,
  output logic                   fault_o,
  output logic                   mmio_o,
  output logic                   atomic_o
);
  cfg_t sel;

  always_comb begin
    sel = '0;
    any_hit_o = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel = cfg_i[i];
        any_hit_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (!any_hit_o) begin
      fault_o  = 1'b1;
      mmio_o   = 1'b1;
      atomic_o = 1'b0;
    end else begin
      mmio_o   = !sel.cache;
      atomic_o = sel.amo;
      unique case (acc_e'(type_i))
        ACC_FETCH:  fault_o = !sel.x;
        ACC_LOAD:   fault_o = !sel.r;
        ACC_STORE:  fault_o = !sel.w;
        ACC_ATOMIC: fault_o = !(sel.r && sel.w && sel.amo);
        ACC_PTW:    fault_o = !sel.r || !sel.cache;
        default:    fault_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pma_attr_unit.sv
module pma_attr_unit
  import pma_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned PADDR_W     = 34,
  parameter int unsigned CFG_BASE    = 'h7C0,
  parameter int unsigned ADDR_BASE   = 'h7D0,
  parameter int unsigned DEF_LO_TOP  = 32'h2000_0000,
  parameter int unsigned DEF_HI_TOP  = 32'h8000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic [1:0]         priv_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic               req_valid_i,
  input  logic [PADDR_W-1:0] req_addr_i,
  input  logic [2:0]         req_type_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic               rsp_mmio_o,
  output logic               rsp_atomic_o
);
  localparam int unsigned AW = PADDR_W - 2;

  cfg_t [NUM_ENTRIES-1:0]         cfg_state;
  logic [NUM_ENTRIES-1:0][AW-1:0] addr_state;
  logic [NUM_ENTRIES-1:0]         hit;
  logic [AW-1:0]                  word;
  logic any_hit, fault_d, mmio_d, atomic_d;

  assign word = req_addr_i[PADDR_W-1:2];

  pma_csr_file #(
    .NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .AW(AW),
    .CFG_BASE(CFG_BASE), .ADDR_BASE(ADDR_BASE),
    .DEF_LO_TOP(DEF_LO_TOP), .DEF_HI_TOP(DEF_HI_TOP)
  ) u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .priv_i  (priv_i),
    .rdata_o (csr_rdata_o),
    .cfg_o   (cfg_state),
    .addr_o  (addr_state)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    logic [AW-1:0] base;
    if (e == 0) begin : g_first
      assign base = '0;
    end else begin : g_rest
      assign base = addr_state[e-1];
    end
    pma_entry_match #(.AW(AW)) u_match (
      .mode_i (cfg_state[e].mode),
      .top_i  (addr_state[e]),
      .base_i (base),
      .word_i (word),
      .hit_o  (hit[e])
    );
  end

  pma_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_resolve (
    .hit_i     (hit),
    .cfg_i     (cfg_state),
    .type_i    (req_type_i),
    .any_hit_o (any_hit),
    .fault_o   (fault_d),
    .mmio_o    (mmio_d),
    .atomic_o  (atomic_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_fault_o  <= 1'b0;
      rsp_mmio_o   <= 1'b0;
      rsp_atomic_o <= 1'b0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      rsp_fault_o  <= fault_d;
      rsp_mmio_o   <= mmio_d;
      rsp_atomic_o <= atomic_d;
    end
  end
endmodule

// File: rtl/pma_attr_unit_sva.sv
module pma_attr_unit_sva #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned AW          = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      csr_we_i,
  input logic [1:0]                priv_i,
  input logic                      req_valid_i,
  input logic [2:0]                req_type_i,
  input logic                      any_hit,
  input logic                      rsp_valid_o,
  input logic                      rsp_fault_o,
  input logic                      rsp_mmio_o,
  input logic                      rsp_atomic_o,
  input logic [NUM_ENTRIES*8-1:0]  cfg_state,
  input logic [NUM_ENTRIES*AW-1:0] addr_state
);
  assert_priv_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && priv_i != 2'b11) |=> ($stable(cfg_state) && $stable(addr_state)));

  assert_atomic_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 3'd3) |=> (rsp_fault_o || rsp_atomic_o));

  assert_no_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !any_hit) |=> (rsp_fault_o && rsp_mmio_o && !rsp_atomic_o));

  assert_rsp_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_rsp_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_ptw_mmio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 3'd4) |=> (!rsp_mmio_o || rsp_fault_o));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_lock
    assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_state[8*e+7] |=> ($stable(cfg_state[8*e +: 8]) && $stable(addr_state[AW*e +: AW])));
  end
endmodule

bind pma_attr_unit pma_attr_unit_sva #(.NUM_ENTRIES(NUM_ENTRIES), .AW(AW)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_we_i     (csr_we_i),
  .priv_i       (priv_i),
  .req_valid_i  (req_valid_i),
  .req_type_i   (req_type_i),
  .any_hit      (any_hit),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_mmio_o   (rsp_mmio_o),
  .rsp_atomic_o (rsp_atomic_o),
  .cfg_state    (cfg_state),
  .addr_state   (addr_state)
);

// File: tb/tb_pma_attr_unit.sv
module tb_pma_attr_unit;
  localparam int unsigned XLEN = 32;
  localparam int unsigned PW   = 34;
  localparam logic [2:0] T_FETCH = 3'd0, T_LOAD = 3'd1, T_STORE = 3'd2,
                         T_ATOMIC = 3'd3, T_PTW = 3'd4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            csr_we_i = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic [1:0]      priv_i = 2'b11;
  logic [XLEN-1:0] csr_rdata_o;
  logic            req_valid_i = 1'b0;
  logic [PW-1:0]   req_addr_i = '0;
  logic [2:0]      req_type_i = '0;
  logic rsp_valid_o, rsp_fault_o, rsp_mmio_o, rsp_atomic_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pma_attr_unit dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] p);
    @(negedge clk_i);
    csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d; priv_i = p;
    @(negedge clk_i);
    csr_we_i = 1'b0; priv_i = 2'b11;
  endtask

  task automatic csr_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    csr_addr_i = a;
    #1;
    chk(tag, csr_rdata_o, exp);
  endtask

  task automatic lookup(input logic [PW-1:0] a, input logic [2:0] t,
                        input logic ef, input logic em, input logic ea, input string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_type_i = t;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid"}, rsp_valid_o, 1'b1);
    chk({tag, " fault"}, rsp_fault_o, ef);
    chk({tag, " mmio"}, rsp_mmio_o, em);
    chk({tag, " atomic"}, rsp_atomic_o, ea);
  endtask

  task automatic t_reset;
    chk("R7 valid low in reset", rsp_valid_o, 1'b0);
    csr_chk(12'h7C0, 32'h0000_6F0F, "R10 cfg0 default");
    csr_chk(12'h7C1, 32'h0, "R10 cfg1 default");
    csr_chk(12'h7C3, 32'h0, "R1 cfg3 default");
    csr_chk(12'h7D0, 32'h2000_0000, "R10 addr0 default");
    csr_chk(12'h7D1, 32'h8000_0000, "R10 addr1 default");
    csr_chk(12'h7DF, 32'h0, "R1 addr15 default");
  endtask

  task automatic t_default_map;
    lookup(34'h0_0000_1000, T_LOAD,   0, 1, 0, "R8 low window load mmio");
    lookup(34'h0_0000_0100, T_FETCH,  0, 1, 0, "R5 low window fetch");
    lookup(34'h0_0000_1000, T_ATOMIC, 1, 1, 0, "R5 atomic to non-atomic region");
    lookup(34'h0_9000_0000, T_ATOMIC, 0, 0, 1, "R5 atomic to main memory");
    lookup(34'h3_0000_0000, T_LOAD,   1, 1, 0, "R6 no match");
    lookup(34'h0_0000_1000, T_PTW,    1, 1, 0, "R8 ptw to mmio");
    lookup(34'h0_9000_0000, T_PTW,    0, 0, 1, "R8 ptw to memory");
  endtask

  task automatic t_priv;
    csr_wr(12'h7C0, 32'h0, 2'b01);
    csr_chk(12'h7C0, 32'h0000_6F0F, "R2 cfg write from S ignored");
    csr_wr(12'h7D0, 32'h0, 2'b00);
    csr_chk(12'h7D0, 32'h2000_0000, "R2 addr write from U ignored");
    lookup(34'h0_0000_1000, T_LOAD, 0, 1, 0, "R2 map intact");
  endtask

  task automatic t_napot;
    // entry 2: 4 KiB at 0x2_8000_0000, read-only cacheable (0x39)
    csr_wr(12'h7D2, 32'hA000_01FF, 2'b11);
    csr_wr(12'h7C0, 32'h0039_6F0F, 2'b11);
    csr_chk(12'h7C0, 32'h0039_6F0F, "R1 cfg0 readback");
    lookup(34'h2_8000_0FFC, T_LOAD,  0, 0, 0, "R4 napot last word");
    lookup(34'h2_8000_1000, T_LOAD,  1, 1, 0, "R4 napot past end");
    lookup(34'h2_8000_0000, T_STORE, 1, 0, 0, "R3 store needs W");
    lookup(34'h2_8000_0000, T_FETCH, 1, 0, 0, "R5 fetch needs X");
  endtask

  task automatic t_na4_tor;
    // entry 3: NA4 at 0x3_0000_0010, RW non-cacheable (0x13)
    csr_wr(12'h7D3, 32'hC000_0004, 2'b11);
    csr_wr(12'h7C0, 32'h1339_6F0F, 2'b11);
    lookup(34'h3_0000_0010, T_LOAD, 0, 1, 0, "R4 na4 hit");
    lookup(34'h3_0000_0014, T_LOAD, 1, 1, 0, "R4 na4 next word misses");
    // entry 4: TOR up to 0x3_0000_4000, lower bound from entry 3
    csr_wr(12'h7D4, 32'hC000_1000, 2'b11);
    csr_wr(12'h7C1, 32'h0000_006F, 2'b11);
    lookup(34'h3_0000_0014, T_LOAD,   0, 0, 1, "R4 tor inside");
    lookup(34'h3_0000_0010, T_LOAD,   0, 1, 0, "R4 lowest entry wins");
    lookup(34'h3_0000_000C, T_LOAD,   1, 1, 0, "R4 tor below base");
    lookup(34'h3_0000_3FFC, T_LOAD,   0, 0, 1, "R4 tor last word");
    lookup(34'h3_0000_4000, T_LOAD,   1, 1, 0, "R4 tor at top");
    lookup(34'h3_0000_0010, T_ATOMIC, 1, 1, 0, "R5 atomic needs amo bit");
  endtask

  task automatic t_lock;
    // entry 5: locked NA4 at 0x3_8000_0000, read-only cacheable (0xB1)
    csr_wr(12'h7D5, 32'hE000_0000, 2'b11);
    csr_wr(12'h7C1, 32'h0000_B16F, 2'b11);
    csr_wr(12'h7C1, 32'h0000_FF6D, 2'b11);
    csr_chk(12'h7C1, 32'h0000_B16D, "R9 locked byte kept, neighbour written");
    csr_wr(12'h7D5, 32'h0, 2'b11);
    csr_chk(12'h7D5, 32'hE000_0000, "R9 locked address kept");
    priv_i = 2'b11;
    lookup(34'h3_8000_0000, T_STORE, 1, 0, 0, "R9 locked region checked in M");
    priv_i = 2'b00;
    lookup(34'h3_8000_0000, T_LOAD,  0, 0, 0, "R9 locked region load in U");
    priv_i = 2'b11;
    lookup(34'h3_0000_0020, T_STORE, 1, 0, 1, "R9 neighbour lost W");
  endtask

  task automatic t_timing;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 34'h2_8000_0000; req_type_i = T_LOAD;
    csr_we_i = 1'b1; csr_addr_i = 12'h7C0; csr_wdata_i = 32'h1300_6F0F; priv_i = 2'b11;
    @(negedge clk_i);
    req_valid_i = 1'b0; csr_we_i = 1'b0;
    chk("R7 valid one cycle later", rsp_valid_o, 1'b1);
    chk("R7 uses table of request cycle", rsp_fault_o, 1'b0);
    @(negedge clk_i);
    chk("R7 valid drops when idle", rsp_valid_o, 1'b0);
    lookup(34'h2_8000_0000, T_LOAD, 1, 1, 0, "R7 new table after write");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_default_map;
    t_priv;
    t_napot;
    t_na4_tor;
    t_lock;
    t_timing;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule